// File: doc/BRIEF.md
# ADC Conversion Trigger and Scan Timer

This block decides when an analog-to-digital conversion begins and paces channel switching during a multi-channel scan on a data acquisition card. Software programs two byte-wide registers over a simple write port. The first register chooses the start source. The start can come from a software strobe or from a falling edge on one of two hardware pins: an external clock line or the output of a cascaded interval timer. The same register also enables DMA requests. The second register holds the analog path settings (range, polarity, gain, per-bank input mode) and a scan dwell code. These settings drive static control outputs toward the front end.

Hardware trigger pins are asynchronous. Each one passes through a synchronizer and a falling-edge detector, and every detected edge produces one single-cycle start pulse. A start request that arrives while the converter reports busy is dropped and recorded in a sticky overrun flag, which a read strobe clears. A channel-advance pulse is produced once per dwell interval while scanning is active. The interval length is computed from a system-clock frequency parameter. A DMA request follows the result FIFO's non-empty state while DMA is enabled.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `conv_start`, `chan_adv`, `dma_req`, `overrun` and all configuration outputs are 0.
- R2: A write with `wr_sel`=1 loads the parameter register, and the outputs show it from the next cycle: bit 7 drives `range_10v` (1 = 10 V), bit 6 drives `unipolar` (0 = bipolar), bits 5:4 drive `gain_code`, bits 3:2 drive `scan_code`, and bits 1:0 drive `se_mode` (1 = single-ended, 0 = differential; bit 0 covers channels 0–7 and 16–23, bit 1 covers channels 8–15 and 24–31). A write with `wr_sel`=0 loads the control register: bit 0 enables DMA, bit 1 enables hardware starts, and bit 2 selects the timer source; bits 7:3 are ignored.
- R3: With hardware starts disabled, `sw_start` high in one cycle gives `conv_start` high in the next cycle, and falling edges on `ext_clk` or `timer_out` give no start.
- R4: With hardware starts enabled and source select 0, each falling edge on `ext_clk` gives exactly one `conv_start` pulse, in the third cycle after the pin changes. Rising edges, `timer_out` edges and `sw_start` give none.
- R5: With hardware starts enabled and source select 1, each falling edge on `timer_out` gives exactly one `conv_start` pulse, with the same latency. `ext_clk` edges give none.
- R6: `conv_start` is high for one cycle per accepted hardware edge.
- R7: While `scan_active` is high, `chan_adv` pulses for one cycle every N cycles, where N = CLK_HZ/1e6 × {20, 15, 10, 4} µs for `scan_code` 00, 01, 10, 11. The first pulse comes N cycles after `scan_active` is first sampled high.
- R8: While `scan_active` is low, `chan_adv` stays 0 and the interval count restarts.
- R9: A start request sampled together with `conv_busy` high produces no `conv_start` and sets `overrun` in the next cycle.
- R10: `overrun` stays set until a cycle with `ovr_rd` high and clears in the following cycle. A new overrun in that same cycle keeps it set.
- R11: `dma_req` is high in the cycle after one in which DMA is enabled, `fifo_empty` is low and `dma_ack` is low; otherwise it is low.
- R12: In the cycle after `dma_ack` is high, `dma_req` is low, so the FIFO empty flag can settle before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = parameter register |
| wr_data | input | 8 | Register write data |
| sw_start | input | 1 | Software conversion start strobe |
| ext_clk | input | 1 | External clock trigger pin (asynchronous) |
| timer_out | input | 1 | Cascaded timer output (asynchronous) |
| conv_busy | input | 1 | Converter busy status |
| scan_active | input | 1 | Channel scan in progress |
| ovr_rd | input | 1 | Overrun read strobe, clears the flag |
| fifo_empty | input | 1 | Result FIFO empty |
| dma_ack | input | 1 | DMA transfer acknowledge |
| conv_start | output | 1 | Single-cycle conversion start |
| chan_adv | output | 1 | Single-cycle channel-advance pulse |
| overrun | output | 1 | Sticky dropped-start flag |
| dma_req | output | 1 | DMA transfer request |
| range_10v | output | 1 | 1 = 10 V range, 0 = 5 V |
| unipolar | output | 1 | 1 = unipolar, 0 = bipolar |
| gain_code | output | 2 | Gain selection |
| scan_code | output | 2 | Scan dwell code |
| se_mode | output | 2 | Per-bank single-ended (1) or differential (0) |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz, so one microsecond equals one cycle. The four dwell codes then give periods of 20, 15, 10 and 4 cycles, and the bench counts every advance pulse exactly over two periods of each code. The synchronizer keeps its default depth of two, which fixes the three-cycle pin-to-start latency that the trigger tests sample at.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    DWELL_20US = 2'b00,
    DWELL_15US = 2'b01,
    DWELL_10US = 2'b10,
    DWELL_4US  = 2'b11
  } dwell_code_e;

  typedef struct packed {
    logic       src_timer;
    logic       hw_en;
    logic       dma_en;
  } trig_ctl_t;

  typedef struct packed {
    logic       range_10v;
    logic       unipolar;
    logic [1:0] gain;
    logic [1:0] dwell;
    logic [1:0] se_mode;
  } conv_par_t;

  function automatic int unsigned dwell_us(input logic [1:0] code);
    case (dwell_code_e'(code))
      DWELL_20US: return 20;
      DWELL_15US: return 15;
      DWELL_10US: return 10;
      default:    return 4;
    endcase
  endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // oldest stage still high, synchronized stage now low
  assign fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output trig_ctl_t  ctl,
  output conv_par_t  par
);
  trig_ctl_t ctl_d;
  conv_par_t par_d;
  logic      ctl_we, par_we;

  always_comb begin
    ctl_we = wr_en & ~wr_sel;
    par_we = wr_en &  wr_sel;
    ctl_d  = ctl;
    par_d  = par;
    if (ctl_we) ctl_d = trig_ctl_t'(wr_data[2:0]);
    if (par_we) par_d = conv_par_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      par <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_d;
      if (par_we) par <= par_d;
    end
  end
endmodule

// File: rtl/adc_scan_timer.sv
module adc_scan_timer
  import adc_trig_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned CNT_W      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] code,
  output logic       adv
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             hit, adv_d;

  always_comb begin
    limit = CNT_W'(dwell_us(code) * CYC_PER_US - 1);
    hit   = (cnt_q >= limit);
    if (!active)  cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
    adv_d = active & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      adv   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      adv   <= adv_d;
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       sw_start,
  input  logic       ext_clk,
  input  logic       timer_out,
  input  logic       conv_busy,
  input  logic       scan_active,
  input  logic       ovr_rd,
  input  logic       fifo_empty,
  input  logic       dma_ack,
  output logic       conv_start,
  output logic       chan_adv,
  output logic       overrun,
  output logic       dma_req,
  output logic       range_10v,
  output logic       unipolar,
  output logic [1:0] gain_code,
  output logic [1:0] scan_code,
  output logic [1:0] se_mode
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned CNT_W      = $clog2(20 * CYC_PER_US);
  localparam int unsigned NUM_HW     = 2;

  trig_ctl_t         ctl;
  conv_par_t         par;
  logic [NUM_HW-1:0] hw_pin, hw_fall;
  logic              hw_en_w, dma_en_w;
  logic              req, start_d, ovr_d, dma_d;

  adc_cfg_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .ctl, .par
  );

  assign hw_pin = {timer_out, ext_clk};

  for (genvar g = 0; g < NUM_HW; g++) begin : g_sync
    adc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .din(hw_pin[g]), .fall(hw_fall[g])
    );
  end

  adc_scan_timer #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_scan (
    .clk, .rst_n, .active(scan_active), .code(par.dwell), .adv(chan_adv)
  );

  assign hw_en_w  = ctl.hw_en;
  assign dma_en_w = ctl.dma_en;

  always_comb begin
    if (ctl.hw_en) req = ctl.src_timer ? hw_fall[1] : hw_fall[0];
    else           req = sw_start;
    start_d = req & ~conv_busy;
    ovr_d   = (req & conv_busy) | (overrun & ~ovr_rd);
    dma_d   = ctl.dma_en & ~fifo_empty & ~dma_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      overrun    <= 1'b0;
      dma_req    <= 1'b0;
    end else begin
      conv_start <= start_d;
      overrun    <= ovr_d;
      dma_req    <= dma_d;
    end
  end

  assign range_10v = par.range_10v;
  assign unipolar  = par.unipolar;
  assign gain_code = par.gain;
  assign scan_code = par.dwell;
  assign se_mode   = par.se_mode;
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_en,
  input logic dma_en,
  input logic conv_busy,
  input logic conv_start,
  input logic overrun,
  input logic ovr_rd,
  input logic dma_ack,
  input logic dma_req,
  input logic scan_active,
  input logic chan_adv
);
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(conv_busy));

  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(conv_busy));

  p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(ovr_rd));

  p_hw_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(hw_en)) |=> !conv_start);

  p_adv_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_adv |=> !chan_adv);

  p_adv_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_active |=> !chan_adv);

  p_dma_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dma_req);

  p_dma_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_req);
endmodule

bind adc_trig_ctrl adc_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en_w), .dma_en(dma_en_w),
  .conv_busy(conv_busy), .conv_start(conv_start), .overrun(overrun),
  .ovr_rd(ovr_rd), .dma_ack(dma_ack), .dma_req(dma_req),
  .scan_active(scan_active), .chan_adv(chan_adv)
);

// File: tb/sim_adc_trig_ctrl.sv
`timescale 1ns/1ps
module sim_adc_trig_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_sel, sw_start, ext_clk, timer_out, conv_busy;
  logic scan_active, ovr_rd, fifo_empty, dma_ack;
  logic [7:0] wr_data;
  logic conv_start, chan_adv, overrun, dma_req, range_10v, unipolar;
  logic [1:0] gain_code, scan_code, se_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_trig_ctrl #(.CLK_HZ(1_000_000), .SYNC_STAGES(2)) u0 (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .sw_start, .ext_clk,
    .timer_out, .conv_busy, .scan_active, .ovr_rd, .fifo_empty, .dma_ack,
    .conv_start, .chan_adv, .overrun, .dma_req, .range_10v, .unipolar,
    .gain_code, .scan_code, .se_mode
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  // count conv_start pulses over n cycles; report the cycle of the first
  task automatic watch_start(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      step();
      if (conv_start) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wr_en = 0; wr_sel = 0; wr_data = 0; sw_start = 0; ext_clk = 1;
    timer_out = 1; conv_busy = 0; scan_active = 0; ovr_rd = 0;
    fifo_empty = 1; dma_ack = 0;
    step(3);
    chk("R1 outputs in reset", {conv_start, chan_adv, overrun, dma_req,
        range_10v, unipolar, gain_code, scan_code, se_mode}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 outputs after release", {conv_start, chan_adv, overrun, dma_req,
        range_10v, unipolar, gain_code, scan_code, se_mode}, 0);
    step(3);
  endtask

  task automatic t_regs();
    wr(1'b1, 8'b1011_0110);
    chk("R2 range_10v", range_10v, 1);
    chk("R2 unipolar", unipolar, 0);
    chk("R2 gain_code", gain_code, 2'b11);
    chk("R2 scan_code", scan_code, 2'b01);
    chk("R2 se_mode", se_mode, 2'b10);
    wr(1'b1, 8'b0100_1001);
    chk("R2 second write", {range_10v, unipolar, gain_code, scan_code, se_mode},
        {1'b0, 1'b1, 2'b00, 2'b10, 2'b01});
    // control write with upper bits set must not disturb parameter outputs
    wr(1'b0, 8'b1111_1000);
    chk("R2 ctl write leaves params", {range_10v, unipolar, gain_code, scan_code, se_mode},
        {1'b0, 1'b1, 2'b00, 2'b10, 2'b01});
  endtask

  task automatic t_sw_start();
    int c, f;
    wr(1'b0, 8'h00);
    sw_start = 1'b1;
    step();
    sw_start = 1'b0;
    chk("R3 sw start next cycle", conv_start, 1);
    step();
    chk("R3 sw start ends", conv_start, 0);
    ext_clk = 1'b0; timer_out = 1'b0;
    watch_start(8, c, f);
    chk("R3 hw edges ignored when disabled", c, 0);
    ext_clk = 1'b1; timer_out = 1'b1;
    step(4);
  endtask

  task automatic t_ext_edge();
    int c, f;
    wr(1'b0, 8'b0000_0010);
    step(4);
    ext_clk = 1'b0;
    watch_start(8, c, f);
    chk("R4 ext fall one pulse", c, 1);
    chk("R4 ext fall latency", f, 3);
    ext_clk = 1'b1;
    watch_start(8, c, f);
    chk("R4 ext rise no pulse", c, 0);
    timer_out = 1'b0;
    watch_start(8, c, f);
    chk("R4 timer edge ignored", c, 0);
    timer_out = 1'b1;
    step(4);
    sw_start = 1'b1;
    step();
    sw_start = 1'b0;
    chk("R4 sw start ignored", conv_start, 0);
    step(4);
    // two edges in a row: each yields one pulse (R6)
    ext_clk = 1'b0; step(3); ext_clk = 1'b1; step(3); ext_clk = 1'b0;
    watch_start(8, c, f);
    chk("R6 second edge one pulse", c, 1);
    ext_clk = 1'b1;
    step(4);
  endtask

  task automatic t_timer_edge();
    int c, f;
    wr(1'b0, 8'b0000_0110);
    step(4);
    timer_out = 1'b0;
    watch_start(8, c, f);
    chk("R5 timer fall one pulse", c, 1);
    chk("R5 timer fall latency", f, 3);
    timer_out = 1'b1;
    step(4);
    ext_clk = 1'b0;
    watch_start(8, c, f);
    chk("R5 ext ignored with timer source", c, 0);
    ext_clk = 1'b1;
    step(4);
  endtask

  task automatic t_scan();
    int per[4] = '{20, 15, 10, 4};
    for (int k = 0; k < 4; k++) begin
      int cnt, p1, p2;
      scan_active = 1'b0;
      wr(1'b1, {4'b0000, 2'(k), 2'b00});
      step(2);
      scan_active = 1'b1;
      cnt = 0; p1 = -1; p2 = -1;
      for (int i = 1; i <= 2 * per[k] + 1; i++) begin
        step();
        if (chan_adv) begin
          cnt++;
          if (p1 < 0) p1 = i; else if (p2 < 0) p2 = i;
        end
      end
      chk($sformatf("R7 code %0d pulse count", k), cnt, 2);
      chk($sformatf("R7 code %0d first pulse", k), p1, per[k]);
      chk($sformatf("R7 code %0d second pulse", k), p2, 2 * per[k]);
    end
    begin
      int cnt;
      scan_active = 1'b0;
      cnt = 0;
      for (int i = 0; i < 25; i++) begin
        step();
        if (chan_adv) cnt++;
      end
      chk("R8 no advance when idle", cnt, 0);
    end
  endtask

  task automatic t_overrun();
    wr(1'b0, 8'h00);
    conv_busy = 1'b1;
    sw_start = 1'b1;
    step();
    sw_start = 1'b0;
    chk("R9 start blocked when busy", conv_start, 0);
    chk("R9 overrun set", overrun, 1);
    step(3);
    chk("R10 overrun sticky", overrun, 1);
    ovr_rd = 1'b1;
    step();
    ovr_rd = 1'b0;
    chk("R10 overrun cleared by read", overrun, 0);
    sw_start = 1'b1; ovr_rd = 1'b1;
    step();
    sw_start = 1'b0; ovr_rd = 1'b0;
    chk("R10 new overrun wins over read", overrun, 1);
    conv_busy = 1'b0;
    ovr_rd = 1'b1;
    step();
    ovr_rd = 1'b0;
    chk("R10 overrun clears again", overrun, 0);
  endtask

  task automatic t_dma();
    wr(1'b0, 8'h00);
    fifo_empty = 1'b0;
    step();
    chk("R11 no request when disabled", dma_req, 0);
    wr(1'b0, 8'h01);
    step();
    chk("R11 request when enabled and data", dma_req, 1);
    dma_ack = 1'b1;
    step();
    dma_ack = 1'b0;
    chk("R12 request drops after ack", dma_req, 0);
    step();
    chk("R11 request returns with data", dma_req, 1);
    fifo_empty = 1'b1;
    step();
    chk("R11 request drops when empty", dma_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_sw_start();
    t_ext_edge();
    t_timer_edge();
    t_scan();
    t_overrun();
    t_dma();
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule